// File: doc/BRIEF.md
# Low-Power Mode Controller

This block governs the two sleep states of a small 8-bit microcontroller core. Software writes a two-bit power-control field. One bit asks for a light sleep, in which only the CPU clock stops. The other asks for a deep sleep, in which every clock and the oscillator stop. While either state is active, the block gates the CPU and peripheral clock enables and forces fixed levels on the address-latch and program-fetch bus strobes.

A light sleep ends on any enabled interrupt request. A deep sleep ends only through the external interrupt pin, and only when that pin is enabled and configured as level-sensitive. Holding the pin low restarts the oscillator. Once the oscillator reports ready, a counter measures how long the pin stays low. If the pin rises after at least `WAKE_CYCLES` counted cycles, the core resumes. If it rises earlier, the core stays asleep and the oscillator stops again. On every wake the block emits a one-cycle pulse, so that execution continues after the instruction that entered the sleep once the interrupt routine returns. An asynchronous hardware reset returns everything to the power-on state.

Top module: `lpm_ctrl`

## Requirements
- R1: After reset the block is in run mode. The CPU clock enable, peripheral clock enable and oscillator run request are 1. The idle, power-down and wake outputs are 0, and both strobes follow the core's strobe inputs.
- R2: In run mode, a write whose data bit 0 is 1 and bit 1 is 0 enters idle. After the next clock edge: CPU clock enable 0, peripheral clock enable 1, oscillator request 1, idle output 1.
- R3: In run mode, a write with data bit 1 set enters power-down. After the next clock edge, both clock enables and the oscillator request are 0 and the power-down output is 1.
- R4: A write that sets both bits enters power-down, not idle.
- R5: The strobe outputs follow the core in run mode. Both are forced to 1 in idle and both are forced to 0 in power-down.
- R6: In idle, an asserted interrupt request returns the block to run mode at the next edge, clears the idle output and raises the wake output.
- R7: In power-down, neither the interrupt request input nor the external pin wakes the block when the pin is disabled or configured as edge-triggered (level-select input 0). The block stays in power-down with the oscillator off.
- R8: In power-down, an enabled, level-configured external pin held low raises the oscillator request at the next edge. Low cycles are counted only while the oscillator-ready input is 1.
- R9: If the pin rises after at least `WAKE_CYCLES` counted low cycles, the next edge returns the block to run mode with a wake pulse.
- R10: If the pin rises with fewer than `WAKE_CYCLES` counted cycles, the block returns to clock-stopped power-down and clears its cycle count. A later attempt must count from zero.
- R11: The wake output is high for exactly one cycle.
- R12: Asserting the asynchronous reset in idle or power-down immediately restores the R1 state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock from the oscillator |
| rst_ni | input | 1 | Asynchronous hardware reset, active low |
| pcon_we_i | input | 1 | Power-control field write strobe |
| pcon_wdata_i | input | 2 | Write data: bit 0 idle, bit 1 power-down |
| irq_req_i | input | 1 | Any enabled interrupt request |
| ext_irq_n_i | input | 1 | External interrupt pin, active low |
| ext_irq_en_i | input | 1 | External interrupt enable |
| ext_irq_level_i | input | 1 | 1 = pin is level-sensitive, 0 = edge-triggered |
| osc_ready_i | input | 1 | Oscillator stable indication |
| ale_core_i | input | 1 | Core address-latch strobe |
| psen_core_i | input | 1 | Core program-fetch strobe |
| cpu_clk_en_o | output | 1 | CPU clock enable |
| per_clk_en_o | output | 1 | Peripheral/timer/interrupt clock enable |
| osc_run_o | output | 1 | Oscillator run request |
| ale_o | output | 1 | Address-latch strobe to the bus |
| psen_o | output | 1 | Program-fetch strobe to the bus |
| idle_o | output | 1 | Idle bit state |
| pd_o | output | 1 | Power-down bit state |
| wake_o | output | 1 | One-cycle wake pulse |

## Verification
The bench builds the controller with `WAKE_CYCLES` set to 16 instead of 1024. This keeps both sides of the hold window within a few dozen cycles: 15 counted cycles must fall back to sleep, and 16 must wake. A short abort followed by a second short attempt shows that the count is cleared, because an uncleared counter would add the two attempts and wake. Stretches with the oscillator-ready input low show that no cycles are counted before the oscillator is stable.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  localparam int unsigned IDLE_BIT = 0;
  localparam int unsigned PD_BIT   = 1;

  typedef enum logic [1:0] {
    ST_RUN     = 2'd0,
    ST_IDLE    = 2'd1,
    ST_PD_STOP = 2'd2,
    ST_PD_WARM = 2'd3
  } lpm_state_e;
endpackage

// File: rtl/lpm_hold_timer.sv
module lpm_hold_timer #(
  parameter int unsigned WAKE_CYCLES = 1024,
  localparam int unsigned CW = $clog2(WAKE_CYCLES + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic count_i,
  output logic done_o
);
  localparam logic [CW-1:0] LIMIT = CW'(WAKE_CYCLES);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= '0;
    else if (clear_i)                cnt_q <= '0;
    else if (count_i && !done_o)     cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = (cnt_q >= LIMIT);

  assert_saturate_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !clear_i) |=> done_o);
  assert_clear_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (cnt_q == '0));
endmodule

// File: rtl/lpm_fsm.sv
module lpm_fsm
  import lpm_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        pcon_we_i,
  input  logic [1:0]  pcon_wdata_i,
  input  logic        irq_req_i,
  input  logic        pin_wake_i,
  input  logic        hold_done_i,
  output lpm_state_e  state_o,
  output logic        wake_o
);
  lpm_state_e state_q, state_d;
  logic wake_q, wake_d;

  always_comb begin
    state_d = state_q;
    wake_d  = 1'b0;
    unique case (state_q)
      ST_RUN: begin
        if (pcon_we_i && pcon_wdata_i[PD_BIT])        state_d = ST_PD_STOP;
        else if (pcon_we_i && pcon_wdata_i[IDLE_BIT]) state_d = ST_IDLE;
      end
      ST_IDLE: begin
        if (irq_req_i) begin
          state_d = ST_RUN;
          wake_d  = 1'b1;
        end
      end
      ST_PD_STOP: begin
        if (pin_wake_i) state_d = ST_PD_WARM;
      end
      ST_PD_WARM: begin
        if (!pin_wake_i) begin
          if (hold_done_i) begin
            state_d = ST_RUN;
            wake_d  = 1'b1;
          end else begin
            state_d = ST_PD_STOP;
          end
        end
      end
      default: state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_RUN;
      wake_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      wake_q  <= wake_d;
    end
  end

  assign state_o = state_q;
  assign wake_o  = wake_q;

  assert_prio_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RUN && pcon_we_i && pcon_wdata_i == 2'b11) |=> (state_q == ST_PD_STOP));
  assert_pd_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_PD_STOP && !pin_wake_i) |=> (state_q == ST_PD_STOP));
  assert_idle_exit_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && irq_req_i) |=> (state_q == ST_RUN && wake_q));
  assert_short_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_PD_WARM && !pin_wake_i && !hold_done_i) |=> (state_q == ST_PD_STOP && !wake_q));
  assert_wake_pulse_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_q |=> !wake_q);
endmodule

// File: rtl/lpm_outmux.sv
module lpm_outmux
  import lpm_pkg::*;
(
  input  lpm_state_e state_i,
  input  logic       ale_core_i,
  input  logic       psen_core_i,
  output logic       cpu_clk_en_o,
  output logic       per_clk_en_o,
  output logic       osc_run_o,
  output logic       ale_o,
  output logic       psen_o,
  output logic       idle_o,
  output logic       pd_o
);
  always_comb begin
    cpu_clk_en_o = 1'b0;
    per_clk_en_o = 1'b0;
    osc_run_o    = 1'b1;
    ale_o        = 1'b0;
    psen_o       = 1'b0;
    idle_o       = 1'b0;
    pd_o         = 1'b0;
    unique case (state_i)
      ST_RUN: begin
        cpu_clk_en_o = 1'b1;
        per_clk_en_o = 1'b1;
        ale_o        = ale_core_i;
        psen_o       = psen_core_i;
      end
      ST_IDLE: begin
        per_clk_en_o = 1'b1;
        ale_o        = 1'b1;
        psen_o       = 1'b1;
        idle_o       = 1'b1;
      end
      ST_PD_STOP: begin
        osc_run_o = 1'b0;
        pd_o      = 1'b1;
      end
      ST_PD_WARM: pd_o = 1'b1;
      default: ;
    endcase
  end

  always_comb begin
    assert_pd_clk_off_R3: assert (!pd_o || (!cpu_clk_en_o && !per_clk_en_o && !ale_o && !psen_o));
  end
endmodule

// File: rtl/lpm_ctrl.sv
module lpm_ctrl
  import lpm_pkg::*;
#(
  parameter int unsigned WAKE_CYCLES = 1024
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       pcon_we_i,
  input  logic [1:0] pcon_wdata_i,
  input  logic       irq_req_i,
  input  logic       ext_irq_n_i,
  input  logic       ext_irq_en_i,
  input  logic       ext_irq_level_i,
  input  logic       osc_ready_i,
  input  logic       ale_core_i,
  input  logic       psen_core_i,
  output logic       cpu_clk_en_o,
  output logic       per_clk_en_o,
  output logic       osc_run_o,
  output logic       ale_o,
  output logic       psen_o,
  output logic       idle_o,
  output logic       pd_o,
  output logic       wake_o
);
  lpm_state_e state;
  logic pin_wake, hold_done, warm;

  // only an enabled level-sensitive low pin may end power-down
  assign pin_wake = ext_irq_en_i && ext_irq_level_i && !ext_irq_n_i;
  assign warm     = (state == ST_PD_WARM);

  lpm_fsm u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .pcon_we_i    (pcon_we_i),
    .pcon_wdata_i (pcon_wdata_i),
    .irq_req_i    (irq_req_i),
    .pin_wake_i   (pin_wake),
    .hold_done_i  (hold_done),
    .state_o      (state),
    .wake_o       (wake_o)
  );

  lpm_hold_timer #(.WAKE_CYCLES(WAKE_CYCLES)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (!warm),
    .count_i (warm && pin_wake && osc_ready_i),
    .done_o  (hold_done)
  );

  lpm_outmux u_out (
    .state_i      (state),
    .ale_core_i   (ale_core_i),
    .psen_core_i  (psen_core_i),
    .cpu_clk_en_o (cpu_clk_en_o),
    .per_clk_en_o (per_clk_en_o),
    .osc_run_o    (osc_run_o),
    .ale_o        (ale_o),
    .psen_o       (psen_o),
    .idle_o       (idle_o),
    .pd_o         (pd_o)
  );

  assert_osc_restart_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pd_o && !osc_run_o && pin_wake) |=> osc_run_o);
  assert_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_clk_en_o && pcon_we_i && pcon_wdata_i == 2'b01) |=> (idle_o && per_clk_en_o && !cpu_clk_en_o));
endmodule

// File: tb/lpm_ctrl_tb.sv
`timescale 1ns/1ps
module lpm_ctrl_tb;
  localparam int unsigned WAKE = 16;
  localparam logic [7:0] E_RUN  = 8'b1110_1000;
  localparam logic [7:0] E_WAKE = 8'b1110_1001;
  localparam logic [7:0] E_IDLE = 8'b0111_1100;
  localparam logic [7:0] E_STOP = 8'b0000_0010;
  localparam logic [7:0] E_WARM = 8'b0010_0010;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic pcon_we = 1'b0, irq = 1'b0, pin_n = 1'b1, pin_en = 1'b0, pin_lvl = 1'b0, ready = 1'b0;
  logic [1:0] wdata = 2'b00;
  logic cpu_en, per_en, osc_run, ale, psen, idle, pd, wake;
  logic [7:0] obs;
  int checks = 0, errors = 0;
  bit finished = 1'b0;
  string q_req[$];
  logic [7:0] q_exp[$];

  always #2 clk = ~clk;

  lpm_ctrl #(.WAKE_CYCLES(WAKE)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .pcon_we_i(pcon_we), .pcon_wdata_i(wdata),
    .irq_req_i(irq), .ext_irq_n_i(pin_n), .ext_irq_en_i(pin_en),
    .ext_irq_level_i(pin_lvl), .osc_ready_i(ready), .ale_core_i(1'b0),
    .psen_core_i(1'b1), .cpu_clk_en_o(cpu_en), .per_clk_en_o(per_en),
    .osc_run_o(osc_run), .ale_o(ale), .psen_o(psen), .idle_o(idle),
    .pd_o(pd), .wake_o(wake)
  );

  assign obs = {cpu_en, per_en, osc_run, ale, psen, idle, pd, wake};

  function automatic void compare(string req, logic [7:0] exp);
    checks++;
    if (obs !== exp) begin
      errors++;
      $display("FAIL %s: outputs %b expected %b", req, obs, exp);
    end
  endfunction

  // driver side: one clock edge, then the expected post-edge outputs
  task automatic tick(input string req, input logic [7:0] exp);
    @(posedge clk);
    #1;
    q_req.push_back(req);
    q_exp.push_back(exp);
  endtask

  // monitor side
  always @(negedge clk) begin
    while (q_exp.size() > 0) compare(q_req.pop_front(), q_exp.pop_front());
  end

  task automatic write_pcon(input logic [1:0] d, input string req, input logic [7:0] exp);
    pcon_we = 1'b1; wdata = d;
    tick(req, exp);
    pcon_we = 1'b0; wdata = 2'b00;
  endtask

  initial begin
    #6 rst_ni = 1'b1;
    tick("R1", E_RUN);

    write_pcon(2'b01, "R2 R5", E_IDLE);
    tick("R2", E_IDLE);
    tick("R2", E_IDLE);
    irq = 1'b1; tick("R6", E_WAKE);
    irq = 1'b0; tick("R11", E_RUN);

    write_pcon(2'b11, "R4 R3 R5", E_STOP);
    irq = 1'b1; tick("R7 irq", E_STOP);
    irq = 1'b0;
    pin_n = 1'b0; pin_en = 1'b1; pin_lvl = 1'b0;
    tick("R7 edge", E_STOP); tick("R7 edge", E_STOP);
    pin_lvl = 1'b1; pin_en = 1'b0;
    tick("R7 disabled", E_STOP);
    pin_en = 1'b1;
    tick("R8 restart", E_WARM);
    for (int i = 0; i < 20; i++) tick("R8 not ready", E_WARM);
    ready = 1'b1;
    for (int i = 0; i < WAKE - 1; i++) tick("R8 count", E_WARM);
    pin_n = 1'b1; tick("R10 short", E_STOP);
    tick("R10 stopped", E_STOP);
    pin_n = 1'b0; tick("R8 restart", E_WARM);
    for (int i = 0; i < 10; i++) tick("R10 recount", E_WARM);
    pin_n = 1'b1; tick("R10 cleared", E_STOP);
    pin_n = 1'b0; tick("R8 restart", E_WARM);
    for (int i = 0; i < WAKE; i++) tick("R9 count", E_WARM);
    tick("R9 held", E_WARM);
    pin_n = 1'b1; tick("R9 wake", E_WAKE);
    tick("R11", E_RUN);

    write_pcon(2'b10, "R3", E_STOP);
    pin_n = 1'b0; tick("R8", E_WARM);
    @(negedge clk); #1;
    rst_ni = 1'b0; #0.5;
    compare("R12 pd", E_RUN);
    @(negedge clk); rst_ni = 1'b1; pin_n = 1'b1;
    tick("R1", E_RUN);

    write_pcon(2'b01, "R2", E_IDLE);
    @(negedge clk); #1;
    rst_ni = 1'b0; #0.5;
    compare("R12 idle", E_RUN);
    @(negedge clk); rst_ni = 1'b1;
    tick("R1", E_RUN);

    @(negedge clk); @(negedge clk);
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #20000;
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: run incomplete, actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule